// File: doc/BRIEF.md
# Pipeline Stage with Shadow-Capture Timing Error Recovery

This block is one register stage of a data pipeline that catches its own setup-time failures. Every data bit is registered twice: once on the main clock and once more by a shadow register on a second clock that rises a little after the main one. A value that arrived too late for the main edge but in time for the delayed edge shows up as a difference between the two copies. The stage treats that difference as a timing error and forwards the shadow copy instead of the main one. It inserts one empty output cycle and holds off the upstream stage for one clock while the corrected word moves forward.

Detected errors also drive a rate monitor. Errors are counted over a window whose length in main-clock cycles is programmable. At the end of each window the count is compared with two programmable limits. A high count produces a one-cycle slow-down request for the operating-point controller. A low count produces a one-cycle speed-up request. A count between the limits produces neither.

Top module: `timing_guard_stage`

## Requirements
- R1: While rst_ni is low, valid_o, stall_o, slow_o and fast_o are all 0.
- R2: When no error occurs, a word accepted with valid_i high at a clk_i edge appears on data_o with valid_o high after the second clk_i edge. Words leave in the order they were accepted, and none is lost or duplicated.
- R3: If the main and shadow copies of an accepted valid word differ, stall_o is high from the delayed edge until the next clk_i edge. At that clk_i edge the stage ignores data_i and valid_i, so upstream must hold its word for one more cycle.
- R4: After the clk_i edge that ends an error cycle, valid_o is low for one cycle and data_o already shows the shadow copy. After the next edge valid_o is high and the same shadow copy is still on data_o.
- R5: A mismatch on a capture made with valid_i low raises no stall_o, creates no bubble and is not counted.
- R6: A window spans win_len_i clk_i cycles, starting at the first edge after reset. A win_len_i of 0 behaves as a window of 1.
- R7: If the error count of a window is strictly greater than thr_hi_i, slow_o is high for exactly the one cycle that follows the window's last clk_i edge.
- R8: If the count is at or below thr_lo_i and no slow-down is issued, fast_o pulses in the same cycle instead. A count above thr_lo_i and at or below thr_hi_i gives neither pulse. When both limits are met, the slow-down wins and the two pulses are never high together.
- R9: The error count saturates at 2^CNT_W-1 (63 by default) and does not wrap, so a window with more errors than that still compares as 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| clk_late_i | input | 1 | Delayed copy of the main clock for the shadow registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid |
| data_i | input | DATA_W | Input word |
| win_len_i | input | WIN_W | Window length in clk_i cycles (0 acts as 1) |
| thr_hi_i | input | CNT_W | Slow-down limit; counts above it trigger slow_o |
| thr_lo_i | input | CNT_W | Speed-up limit; counts at or below it trigger fast_o |
| data_o | output | DATA_W | Output word, corrected when an error was seen |
| valid_o | output | 1 | Output word is valid |
| stall_o | output | 1 | Hold request to upstream during an error cycle |
| slow_o | output | 1 | One-cycle slow-down recommendation |
| fast_o | output | 1 | One-cycle speed-up recommendation |

## Verification
A wrong capture-valid or mismatch state shows up in the same cycle on stall_o. After the next clk_i edge it appears as a missing bubble, a repeated word or a word out of order on data_o. A wrong window position or error count stays hidden until the window closes, so it appears one cycle after the window's last edge as a pulse that is missing, misplaced or of the wrong kind. A wrapping counter is therefore only exposed by a window that holds more errors than the counter can represent. Comparing every output cycle against an independent cycle model catches these faults at the first window boundary where they matter.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    REC_NONE = 2'd0,
    REC_SLOW = 2'd1,
    REC_FAST = 2'd2
  } rec_e;
endpackage

// File: rtl/tg_capture.sv
module tg_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              clk_late_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] cap_data_o,
  output logic [DATA_W-1:0] shd_data_o,
  output logic              cap_vld_o,
  output logic              mis_o
);
  logic [DATA_W-1:0] cap_q, shd_q, diff;
  logic              vld_q;

  // main capture; an error cycle drops the incoming word (upstream holds it)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      vld_q <= 1'b0;
    end else if (mis_o) begin
      vld_q <= 1'b0;
    end else begin
      cap_q <= data_i;
      vld_q <= valid_i;
    end
  end

  always_ff @(posedge clk_late_i or negedge rst_ni) begin
    if (!rst_ni) shd_q <= '0;
    else         shd_q <= data_i;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit_cmp
    assign diff[b] = cap_q[b] ^ shd_q[b];
  end

  assign mis_o      = vld_q & (|diff);
  assign cap_data_o = cap_q;
  assign shd_data_o = shd_q;
  assign cap_vld_o  = vld_q;

  p_stall_drops_input_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_o |=> !cap_vld_o);
endmodule

// File: rtl/tg_recover.sv
module tg_recover #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic [DATA_W-1:0] shd_data_i,
  input  logic              cap_vld_i,
  input  logic              mis_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] out_q;
  logic              vld_q, fix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      vld_q <= 1'b0;
      fix_q <= 1'b0;
    end else if (mis_i) begin
      out_q <= shd_data_i;   // corrected word, bubble this cycle
      vld_q <= 1'b0;
      fix_q <= 1'b1;
    end else if (fix_q) begin
      vld_q <= 1'b1;         // release corrected word
      fix_q <= 1'b0;
    end else begin
      out_q <= cap_data_i;
      vld_q <= cap_vld_i;
    end
  end

  assign data_o  = out_q;
  assign valid_o = vld_q;

  p_pass_through_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_vld_i && !mis_i && !fix_q) |=> (valid_o && data_o == $past(cap_data_i)));
  p_bubble_shadow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_i |=> (!valid_o && data_o == $past(shd_data_i)));
  p_fix_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_i |-> ##2 (valid_o && $stable(data_o)));
endmodule

// File: rtl/tg_rate_mon.sv
module tg_rate_mon
  import tg_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned WIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [CNT_W-1:0] thr_hi_i,
  input  logic [CNT_W-1:0] thr_lo_i,
  output logic             slow_o,
  output logic             fast_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [WIN_W-1:0] cyc_q, win_eff;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             win_last;
  rec_e             rec_d, rec_q;

  assign win_eff  = (win_len_i == '0) ? WIN_W'(1) : win_len_i;
  assign win_last = ({1'b0, cyc_q} + (WIN_W+1)'(1)) >= {1'b0, win_eff};
  assign cnt_nxt  = (err_i && cnt_q != CntMax) ? cnt_q + CNT_W'(1) : cnt_q;

  always_comb begin
    rec_d = REC_NONE;
    if (win_last) begin
      if (cnt_nxt > thr_hi_i)       rec_d = REC_SLOW;
      else if (cnt_nxt <= thr_lo_i) rec_d = REC_FAST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      cnt_q <= '0;
      rec_q <= REC_NONE;
    end else begin
      rec_q <= rec_d;
      if (win_last) begin
        cyc_q <= '0;
        cnt_q <= '0;
      end else begin
        cyc_q <= cyc_q + WIN_W'(1);
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign slow_o = (rec_q == REC_SLOW);
  assign fast_o = (rec_q == REC_FAST);

  p_one_verdict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slow_o && fast_o));
  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax && !win_last) |=> cnt_q == CntMax);
  p_pulse_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_last && cnt_nxt > thr_hi_i) |=> slow_o);
endmodule

// File: rtl/timing_guard_stage.sv
module timing_guard_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned WIN_W  = 10
) (
  input  logic              clk_i,
  input  logic              clk_late_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [CNT_W-1:0]  thr_hi_i,
  input  logic [CNT_W-1:0]  thr_lo_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              stall_o,
  output logic              slow_o,
  output logic              fast_o
);
  logic [DATA_W-1:0] cap_data, shd_data;
  logic              cap_vld, mis;

  tg_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i      (clk_i),
    .clk_late_i (clk_late_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .data_i     (data_i),
    .cap_data_o (cap_data),
    .shd_data_o (shd_data),
    .cap_vld_o  (cap_vld),
    .mis_o      (mis)
  );

  tg_recover #(.DATA_W(DATA_W)) u_recover (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_data_i (cap_data),
    .shd_data_i (shd_data),
    .cap_vld_i  (cap_vld),
    .mis_i      (mis),
    .data_o     (data_o),
    .valid_o    (valid_o)
  );

  tg_rate_mon #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_i     (mis),
    .win_len_i (win_len_i),
    .thr_hi_i  (thr_hi_i),
    .thr_lo_i  (thr_lo_i),
    .slow_o    (slow_o),
    .fast_o    (fast_o)
  );

  assign stall_o = mis;

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !stall_o && !slow_o && !fast_o));
endmodule

// File: tb/tb_timing_guard_stage.sv
module tb_timing_guard_stage;
  localparam int CLK_P  = 10;
  localparam int DW     = 16;
  localparam int CW     = 6;
  localparam int WW     = 10;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk, clk_late, rst_ni, valid_i;
  logic [DW-1:0] data_i, data_o;
  logic [WW-1:0] win_len;
  logic [CW-1:0] thr_hi, thr_lo;
  logic          valid_o, stall_o, slow_o, fast_o;

  int checks, errors;
  logic [DW-1:0] q[$];
  bit inj_flag, bub_now, fix_now, exp_slow, exp_fast;
  int cyc, cnt, saw_slow;
  string slow_tag;

  timing_guard_stage #(.DATA_W(DW), .CNT_W(CW), .WIN_W(WW)) dut (
    .clk_i(clk), .clk_late_i(clk_late), .rst_ni(rst_ni),
    .valid_i(valid_i), .data_i(data_i),
    .win_len_i(win_len), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo),
    .data_o(data_o), .valid_o(valid_o), .stall_o(stall_o),
    .slow_o(slow_o), .fast_o(fast_o)
  );

  initial begin clk = 0; forever #(CLK_P/2) clk = ~clk; end
  initial begin clk_late = 0; #3; forever #(CLK_P/2) clk_late = ~clk_late; end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference cycle model, from the requirements
  always @(posedge clk) begin
    if (!rst_ni) begin
      cyc = 0; cnt = 0; exp_slow = 0; exp_fast = 0;
      bub_now = 0; fix_now = 0; inj_flag = 0;
    end else begin
      automatic bit e = inj_flag;
      automatic int wef = (win_len == 0) ? 1 : int'(win_len);
      inj_flag = 0;
      fix_now = bub_now;
      bub_now = e;
      if (e && cnt < CMAX) cnt++;
      exp_slow = 0; exp_fast = 0;
      if (cyc == wef - 1) begin
        if (cnt > int'(thr_hi)) exp_slow = 1;
        else if (cnt <= int'(thr_lo)) exp_fast = 1;
        cnt = 0; cyc = 0;
      end else cyc++;
    end
  end

  // output checker
  always @(negedge clk) begin
    if (!rst_ni) begin
      chk(!valid_o && !stall_o && !slow_o && !fast_o, "R1",
          {valid_o, stall_o, slow_o, fast_o}, 0);
    end else begin
      chk(stall_o == inj_flag, "R3 R5 stall", stall_o, inj_flag);
      chk(slow_o == exp_slow, slow_tag, slow_o, exp_slow);
      chk(fast_o == exp_fast, "R8 fast", fast_o, exp_fast);
      if (slow_o) saw_slow++;
      if (bub_now) begin
        chk(!valid_o, "R4 bubble", valid_o, 0);
        chk(q.size() > 0 && data_o == q[0], "R4 shadow data", data_o, q.size() > 0 ? q[0] : 0);
      end else begin
        if (fix_now) chk(valid_o, "R4 release", valid_o, 1);
        if (valid_o) begin
          if (q.size() == 0) chk(0, "R2 unexpected word", data_o, 0);
          else begin
            automatic logic [DW-1:0] ex = q.pop_front();
            chk(data_o == ex, "R2 data", data_o, ex);
          end
        end
      end
    end
  end

  task automatic do_reset(input int w, input int hi, input int lo);
    rst_ni = 0; valid_i = 0; data_i = '0;
    win_len = WW'(w); thr_hi = CW'(hi); thr_lo = CW'(lo);
    q.delete();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
  endtask

  // called at negedge+1; mode 1 = late glitch after the main edge
  task automatic step(input bit v, input logic [DW-1:0] d, input bit glitch);
    logic [DW-1:0] mask;
    while (stall_o) begin @(negedge clk); #1; end
    mask = DW'(($urandom % ((1 << DW) - 1)) + 1);
    valid_i = v; data_i = d;
    if (v) q.push_back(glitch ? (d ^ mask) : d);
    @(posedge clk); #1;
    if (glitch) begin
      data_i = d ^ mask;
      if (v) inj_flag = 1;
    end
    @(negedge clk); #1;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(0, DW'($urandom), 0);
    chk(q.size() == 0, "R2 drained", q.size(), 0);
  endtask

  task automatic rand_run(input int n, input int pv, input int pg);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < pv, DW'($urandom), ($urandom % 100) < pg);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    checks = 0; errors = 0; saw_slow = 0; slow_tag = "R7 slow";
    do_reset(20, 3, 1);
    // R2 directed latency
    step(1, 16'hA5A5, 0);
    chk(!valid_o, "R2 latency one edge", valid_o, 0);
    step(0, 16'h0000, 0);
    chk(valid_o && data_o == 16'hA5A5, "R2 latency two edges", data_o, 16'hA5A5);
    // R4 directed glitch, R5 invalid glitch
    step(1, 16'h1234, 1);
    chk(stall_o, "R3 directed stall", stall_o, 1);
    step(0, 16'h5555, 1);
    chk(!stall_o, "R5 invalid glitch", stall_o, 0);
    drain();
    // random traffic, R7 R8 at moderate rates
    rand_run(400, 80, 15);
    drain();
    // R6 window of 0 acts as 1
    slow_tag = "R6 slow";
    do_reset(0, 0, 0);
    rand_run(200, 70, 30);
    drain();
    // R8 misordered limits: slow wins
    slow_tag = "R8 slow priority";
    do_reset(30, 2, 5);
    rand_run(300, 90, 12);
    drain();
    // R9 saturation: >63 errors in one window
    slow_tag = "R9 slow";
    do_reset(300, 62, 0);
    saw_slow = 0;
    for (int i = 0; i < 160; i++) step(1, DW'($urandom), 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0);
    chk(saw_slow >= 1, "R9 saturated count", saw_slow, 1);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule